// File: doc/BRIEF.md
# Tagged Load Execution Unit

This block is the execute-stage load path of a 64-bit register machine. Each general register carries a one-bit deferred-exception tag, called the poison bit. The unit accepts one decoded load at a time. Each load carries an access size, a load kind (plain, speculative or tag-restoring fill), an addressing form, and the base, index and target register numbers with their values and tags. For each accepted load the unit reads memory once through a valid/ready request port. The response arrives on the cycle after the handshake. The unit zero-extends the result and emits a one-cycle writeback for the target register.

The two update forms work as follows. The unit computes a new base from a signed 9-bit immediate or from the index register. It writes that new base back to the base register once the access is done. It also issues a prefetch hint to the new address, carrying the locality hint. Poison on the index register flows into the new base tag. Poison on the base register raises a fault for non-speculative kinds. For speculative loads it is deferred into the target tag instead. A fill load restores the target tag from a 64-bit spill-tag register input.

All results are registered. `done` pulses for one cycle per accepted load, together with the writebacks or the fault report.

Top module: `ld_exec_unit`

## Requirements
- R1: The access reads the number of bytes given by the size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: 8 bytes). The request carries that code. The target value is the low bytes of the response, zero-extended to 64 bits.
- R2: A plain load (kind 0) or a speculative load (kind 1) whose base tag is clear writes the target with its tag cleared.
- R3: A fill load (kind 2) always requests 8 bytes. It writes the target tag from bit addr[8:3] of the spill-tag input, where addr is the load address.
- R4: Form 1 writes the base back as base plus the sign-extended imm9. Form 2 writes it back as base plus index. Form 0 writes no base.
- R5: The memory request address is always the base value before any update.
- R6: In form 2 the written-back base tag is the OR of the base tag and the index tag. A set index tag alone raises no fault.
- R7: A non-speculative load whose base tag is set reports fault code 1. It issues no memory request and writes no register.
- R8: A speculative load whose base tag is set issues no memory request. It writes value 0 with tag 1 to the target and still performs the base update of its form.
- R9: Forms 1 and 2 emit one prefetch pulse with the post-update address and the hint field, unless the written-back base tag is set. Form 0 emits no prefetch.
- R10: In forms 1 and 2, equal target and base register numbers report fault code 2, with no request and no writes. This check takes priority over code 1.
- R11: After reset, op_ready is 1 and every pulse output is 0. Each accepted load yields exactly one `done` pulse, and op_ready stays low while a memory access is pending.
- R12: Once raised, a memory request holds its valid, address and size stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| op_valid | input | 1 | load operation offered |
| op_ready | output | 1 | unit idle and able to take an operation |
| op_size | input | 2 | size code 0..3 = 1,2,4,8 bytes |
| op_kind | input | 2 | 0 plain, 1 speculative, 2 fill |
| op_form | input | 2 | 0 no update, 1 immediate update, 2 index update |
| op_hint | input | 2 | locality hint passed to the prefetch |
| op_imm | input | 9 | signed update immediate |
| op_dst_idx | input | 7 | target register number |
| op_base_idx | input | 7 | base register number |
| op_base_val | input | 64 | base register value |
| op_base_tag | input | 1 | base register poison bit |
| op_index_val | input | 64 | index register value |
| op_index_tag | input | 1 | index register poison bit |
| spill_tags | input | 64 | spill-tag register used by fill loads |
| mem_req_valid | output | 1 | memory read request |
| mem_req_ready | input | 1 | memory accepts the request |
| mem_req_addr | output | 64 | byte address of the read |
| mem_req_size | output | 2 | size code of the read |
| mem_rsp_data | input | 64 | read data, valid the cycle after the handshake |
| dst_we | output | 1 | target register write pulse |
| dst_idx | output | 7 | target register number |
| dst_val | output | 64 | target register value |
| dst_tag | output | 1 | target register poison bit |
| base_we | output | 1 | base register write pulse |
| base_idx | output | 7 | base register number |
| base_val | output | 64 | updated base value |
| base_tag | output | 1 | updated base poison bit |
| pf_valid | output | 1 | prefetch hint pulse |
| pf_addr | output | 64 | prefetch address |
| pf_hint | output | 2 | prefetch locality hint |
| done | output | 1 | operation complete pulse |
| fault_valid | output | 1 | fault report pulse |
| fault_code | output | 2 | 1 poison consumption, 2 illegal operation |

## Verification
A wrongly latched address or size shows at the memory port on the first request cycle. A wrong mask or tag selection shows on the writeback pulse one cycle after the response. A misrouted fault decision, or a deferral applied to the wrong load kind, shows as a stray request or a wrong writeback on the `done` cycle of that same load, which is at most two cycles after the handshake. A stuck sequencer shows as a missing `done`, or an op_ready that never returns, before the next load can be offered.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [1:0] {KIND_PLAIN = 2'd0, KIND_SPEC = 2'd1, KIND_FILL = 2'd2, KIND_RSVD = 2'd3} kind_e;
  typedef enum logic [1:0] {FORM_NONE = 2'd0, FORM_IMM = 2'd1, FORM_INDEX = 2'd2, FORM_RSVD = 2'd3} form_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_POISON = 2'd1, FLT_ILLEGAL = 2'd2} fault_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_RSP = 2'd2} state_e;
  localparam logic [1:0] SIZE_MAX = 2'd3;
endpackage

// File: rtl/ld_addr_gen.sv
module ld_addr_gen
  import ld_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 9
) (
  input  logic [1:0]       form,
  input  logic [XLEN-1:0]  base_val,
  input  logic             base_tag,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  index_val,
  input  logic             index_tag,
  output logic             upd_en,
  output logic [XLEN-1:0]  upd_val,
  output logic             upd_tag
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sx;
  form_e           f;

  assign f      = form_e'(form);
  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    upd_en  = 1'b0;
    upd_val = base_val;
    upd_tag = base_tag;
    unique case (f)
      FORM_IMM: begin
        upd_en  = 1'b1;
        upd_val = base_val + imm_sx;
      end
      FORM_INDEX: begin
        upd_en  = 1'b1;
        upd_val = base_val + index_val;
        upd_tag = base_tag | index_tag;
      end
      default: begin
        upd_en  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ld_fault_chk.sv
module ld_fault_chk
  import ld_pkg::*;
#(
  parameter int RIDX_W = 7
) (
  input  logic [1:0]        kind,
  input  logic [1:0]        form,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic              base_tag,
  output logic              illegal,
  output logic              poison_flt,
  output logic              defer
);
  logic is_update;
  logic is_spec;

  assign is_update  = (form_e'(form) == FORM_IMM) || (form_e'(form) == FORM_INDEX);
  assign is_spec    = (kind_e'(kind) == KIND_SPEC);
  assign illegal    = is_update && (dst_idx == base_idx);
  assign poison_flt = !illegal && !is_spec && base_tag;
  assign defer      = !illegal && is_spec && base_tag;
endmodule

// File: rtl/ld_data_fmt.sv
module ld_data_fmt #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] spill,
  input  logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] ext,
  output logic            spill_bit
);
  localparam int NSIZE = 4;
  localparam int LSB   = $clog2(XLEN / 8);
  localparam int SEL_W = $clog2(XLEN);

  logic [XLEN-1:0] ext_v [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_sz
    localparam int NB = 8 << g;
    if (NB >= XLEN) begin : g_full
      assign ext_v[g] = raw;
    end else begin : g_part
      assign ext_v[g] = {{(XLEN-NB){1'b0}}, raw[NB-1:0]};
    end
  end

  assign ext       = ext_v[size];
  assign spill_bit = spill[addr[LSB +: SEL_W]];
endmodule

// File: rtl/ld_exec_unit.sv
module ld_exec_unit
  import ld_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 7,
  parameter int IMM_W  = 9,
  parameter int HINT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_size,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        op_form,
  input  logic [HINT_W-1:0] op_hint,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [RIDX_W-1:0] op_dst_idx,
  input  logic [RIDX_W-1:0] op_base_idx,
  input  logic [XLEN-1:0]   op_base_val,
  input  logic              op_base_tag,
  input  logic [XLEN-1:0]   op_index_val,
  input  logic              op_index_tag,
  input  logic [XLEN-1:0]   spill_tags,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [1:0]        mem_req_size,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              dst_we,
  output logic [RIDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]   dst_val,
  output logic              dst_tag,
  output logic              base_we,
  output logic [RIDX_W-1:0] base_idx,
  output logic [XLEN-1:0]   base_val,
  output logic              base_tag,
  output logic              pf_valid,
  output logic [XLEN-1:0]   pf_addr,
  output logic [HINT_W-1:0] pf_hint,
  output logic              done,
  output logic              fault_valid,
  output logic [1:0]        fault_code
);
  state_e            state_q;
  logic [XLEN-1:0]   addr_q;
  logic [1:0]        size_q;
  logic              fill_q;
  logic              spill_q;
  logic [RIDX_W-1:0] dst_idx_q;
  logic [RIDX_W-1:0] base_idx_q;
  logic              upd_en_q;
  logic [XLEN-1:0]   upd_val_q;
  logic              upd_tag_q;
  logic [HINT_W-1:0] hint_q;

  logic              upd_en;
  logic [XLEN-1:0]   upd_val;
  logic              upd_tag;
  logic              illegal;
  logic              poison_flt;
  logic              defer;
  logic [XLEN-1:0]   ext_data;
  logic              spill_unused;
  logic              spill_bit;
  logic [1:0]        size_eff;
  logic              accept;

  assign accept   = (state_q == ST_IDLE) && op_valid;
  assign size_eff = (kind_e'(op_kind) == KIND_FILL) ? SIZE_MAX : op_size;

  ld_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
    .form      (op_form),
    .base_val  (op_base_val),
    .base_tag  (op_base_tag),
    .imm       (op_imm),
    .index_val (op_index_val),
    .index_tag (op_index_tag),
    .upd_en    (upd_en),
    .upd_val   (upd_val),
    .upd_tag   (upd_tag)
  );

  ld_fault_chk #(.RIDX_W(RIDX_W)) u_flt (
    .kind       (op_kind),
    .form       (op_form),
    .dst_idx    (op_dst_idx),
    .base_idx   (op_base_idx),
    .base_tag   (op_base_tag),
    .illegal    (illegal),
    .poison_flt (poison_flt),
    .defer      (defer)
  );

  // tag selection happens at accept time on the pre-update address
  ld_data_fmt #(.XLEN(XLEN)) u_sel (
    .raw       (op_base_val),
    .size      (2'd0),
    .spill     (spill_tags),
    .addr      (op_base_val),
    .ext       (),
    .spill_bit (spill_bit)
  );

  // formatting of the returned data
  ld_data_fmt #(.XLEN(XLEN)) u_fmt (
    .raw       (mem_rsp_data),
    .size      (size_q),
    .spill     (spill_tags),
    .addr      (addr_q),
    .ext       (ext_data),
    .spill_bit (spill_unused)
  );

  assign op_ready      = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_size  = size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      size_q      <= '0;
      fill_q      <= 1'b0;
      spill_q     <= 1'b0;
      dst_idx_q   <= '0;
      base_idx_q  <= '0;
      upd_en_q    <= 1'b0;
      upd_val_q   <= '0;
      upd_tag_q   <= 1'b0;
      hint_q      <= '0;
      dst_we      <= 1'b0;
      dst_idx     <= '0;
      dst_val     <= '0;
      dst_tag     <= 1'b0;
      base_we     <= 1'b0;
      base_idx    <= '0;
      base_val    <= '0;
      base_tag    <= 1'b0;
      pf_valid    <= 1'b0;
      pf_addr     <= '0;
      pf_hint     <= '0;
      done        <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
    end else begin
      dst_we      <= 1'b0;
      base_we     <= 1'b0;
      pf_valid    <= 1'b0;
      done        <= 1'b0;
      fault_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q     <= op_base_val;
            size_q     <= size_eff;
            fill_q     <= (kind_e'(op_kind) == KIND_FILL);
            spill_q    <= spill_bit;
            dst_idx_q  <= op_dst_idx;
            base_idx_q <= op_base_idx;
            upd_en_q   <= upd_en;
            upd_val_q  <= upd_val;
            upd_tag_q  <= upd_tag;
            hint_q     <= op_hint;
            if (illegal || poison_flt) begin
              fault_valid <= 1'b1;
              fault_code  <= illegal ? FLT_ILLEGAL : FLT_POISON;
              done        <= 1'b1;
            end else if (defer) begin
              fault_code <= FLT_NONE;
              dst_we     <= 1'b1;
              dst_idx    <= op_dst_idx;
              dst_val    <= '0;
              dst_tag    <= 1'b1;
              base_we    <= upd_en;
              base_idx   <= op_base_idx;
              base_val   <= upd_val;
              base_tag   <= upd_tag;
              pf_valid   <= upd_en && !upd_tag;
              pf_addr    <= upd_val;
              pf_hint    <= op_hint;
              done       <= 1'b1;
            end else begin
              fault_code <= FLT_NONE;
              state_q    <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_RSP;
        end
        ST_RSP: begin
          dst_we   <= 1'b1;
          dst_idx  <= dst_idx_q;
          dst_val  <= ext_data;
          dst_tag  <= fill_q ? spill_q : 1'b0;
          base_we  <= upd_en_q;
          base_idx <= base_idx_q;
          base_val <= upd_val_q;
          base_tag <= upd_tag_q;
          pf_valid <= upd_en_q && !upd_tag_q;
          pf_addr  <= upd_val_q;
          pf_hint  <= hint_q;
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ld_exec_unit_chk.sv
module ld_exec_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            op_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic [1:0]      mem_req_size,
  input logic            dst_we,
  input logic            base_we,
  input logic            pf_valid,
  input logic            done,
  input logic            fault_valid,
  input logic [1:0]      fault_code
);
  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!dst_we && !base_we && !pf_valid));

  assert_fault_code_R10: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_code == 2'd1 || fault_code == 2'd2));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)));

  assert_pf_with_update_R9: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> base_we);

  assert_write_done_R11: assert property (@(posedge clk) disable iff (rst)
    (dst_we || fault_valid) |-> done);

  assert_busy_no_ready_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !op_ready);
endmodule

bind ld_exec_unit ld_exec_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .op_ready      (op_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .dst_we        (dst_we),
  .base_we       (base_we),
  .pf_valid      (pf_valid),
  .done          (done),
  .fault_valid   (fault_valid),
  .fault_code    (fault_code)
);

// File: tb/ld_exec_unit_tb_top.sv
module ld_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0, op_kind = '0, op_form = '0, op_hint = '0;
  logic [8:0]  op_imm = '0;
  logic [6:0]  op_dst_idx = '0, op_base_idx = '0;
  logic [63:0] op_base_val = '0, op_index_val = '0, spill_tags = '0;
  logic        op_base_tag = 1'b0, op_index_tag = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr, mem_rsp_data = '0;
  logic [1:0]  mem_req_size;
  logic        dst_we, dst_tag, base_we, base_tag, pf_valid, done, fault_valid;
  logic [6:0]  dst_idx, base_idx;
  logic [63:0] dst_val, base_val, pf_addr;
  logic [1:0]  pf_hint, fault_code;

  always #2.5 clk = ~clk;

  ld_exec_unit dut_i (.*);

  typedef struct {
    logic        flt;  logic [1:0] code;
    logic        mem;  logic [63:0] maddr; logic [1:0] msize;
    logic        dwe;  logic [6:0] didx; logic [63:0] dval; logic dtag;
    logic        bwe;  logic [6:0] bidx; logic [63:0] bval; logic btag;
    logic        pfv;  logic [63:0] paddr; logic [1:0] phint;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0, req_cnt = 0, seen_cnt = 0, sent = 0, dones = 0;
  logic [63:0] last_addr;
  logic [1:0]  last_size;
  bit finished = 0;

  function automatic logic [63:0] rsp_fn(logic [63:0] a);
    return a ^ {a[31:0], a[63:32]} ^ 64'h9E37_79B9_7F4A_7C15;
  endfunction

  // memory model: response the cycle after handshake
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_data <= rsp_fn(mem_req_addr);
      last_addr    <= mem_req_addr;
      last_size    <= mem_req_size;
      req_cnt      <= req_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] sz, kind, form, hint, input logic [8:0] imm,
                                 input logic [6:0] d, b, input logic [63:0] bv, iv, sp,
                                 input logic bt, it);
    exp_t e;
    logic [1:0] es;
    logic [63:0] m;
    e = '{default: '0};
    es = (kind == 2) ? 2'd3 : sz;
    if (form != 0 && d == b) begin e.flt = 1; e.code = 2; return e; end
    if (kind != 1 && bt) begin e.flt = 1; e.code = 1; return e; end
    e.bwe = (form != 0); e.bidx = b; e.btag = bt;
    if (form == 1) e.bval = bv + {{55{imm[8]}}, imm};
    if (form == 2) begin e.bval = bv + iv; e.btag = bt | it; end
    e.pfv = e.bwe && !e.btag; e.paddr = e.bval; e.phint = hint;
    e.dwe = 1; e.didx = d;
    if (kind == 1 && bt) begin e.dval = 0; e.dtag = 1; return e; end
    e.mem = 1; e.maddr = bv; e.msize = es;
    m = (es == 3) ? '1 : ((64'd1 << (8 << es)) - 1);
    e.dval = rsp_fn(bv) & m;
    e.dtag = (kind == 2) ? sp[bv[8:3]] : 1'b0;
    return e;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      int nreq;
      dones++;
      nreq = req_cnt - seen_cnt;
      seen_cnt = req_cnt;
      if (exp_q.size() == 0) chk(0, "R11 unexpected done", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk(fault_valid == e.flt, "R7/R10 fault_valid", fault_valid, e.flt);
        if (e.flt) chk(fault_code == e.code, (e.code == 2) ? "R10 code" : "R7 code", fault_code, e.code);
        chk(nreq == (e.mem ? 1 : 0), e.flt ? "R7 request count" : "R8 request count", nreq, e.mem);
        if (e.mem) begin
          chk(last_addr == e.maddr, "R5 request address", last_addr, e.maddr);
          chk(last_size == e.msize, "R3 request size", last_size, e.msize);
        end
        chk(dst_we == e.dwe, "R2 dst_we", dst_we, e.dwe);
        if (e.dwe) begin
          chk(dst_idx == e.didx, "R2 dst_idx", dst_idx, e.didx);
          chk(dst_val == e.dval, "R1 dst_val", dst_val, e.dval);
          chk(dst_tag == e.dtag, "R3 dst_tag", dst_tag, e.dtag);
        end
        chk(base_we == e.bwe, "R4 base_we", base_we, e.bwe);
        if (e.bwe) begin
          chk(base_idx == e.bidx, "R4 base_idx", base_idx, e.bidx);
          chk(base_val == e.bval, "R4 base_val", base_val, e.bval);
          chk(base_tag == e.btag, "R6 base_tag", base_tag, e.btag);
        end
        chk(pf_valid == e.pfv, "R9 pf_valid", pf_valid, e.pfv);
        if (e.pfv) begin
          chk(pf_addr == e.paddr, "R9 pf_addr", pf_addr, e.paddr);
          chk(pf_hint == e.phint, "R9 pf_hint", pf_hint, e.phint);
        end
      end
    end
  end

  // request stall pattern (R12 is exercised by the held request)
  always @(negedge clk) mem_req_ready <= ($urandom % 3) != 0;

  task automatic send(input logic [1:0] sz, kind, form, hint, input logic [8:0] imm,
                      input logic [6:0] d, b, input logic [63:0] bv, iv, sp,
                      input logic bt, it);
    exp_t e;
    while (!op_ready) @(negedge clk);
    e = model(sz, kind, form, hint, imm, d, b, bv, iv, sp, bt, it);
    exp_q.push_back(e);
    sent++;
    op_valid = 1; op_size = sz; op_kind = kind; op_form = form; op_hint = hint;
    op_imm = imm; op_dst_idx = d; op_base_idx = b; op_base_val = bv; op_index_val = iv;
    spill_tags = sp; op_base_tag = bt; op_index_tag = it;
    @(negedge clk);
    op_valid = 0;
    if (e.mem) chk(op_ready == 0, "R11 busy op_ready", op_ready, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(op_ready == 1 && done == 0 && dst_we == 0 && base_we == 0 && pf_valid == 0
        && fault_valid == 0 && mem_req_valid == 0, "R11 reset state", op_ready, 1);
    // R1 each size, plain, no update
    for (int s = 0; s < 4; s++)
      send(s[1:0], 0, 0, 0, 0, 7'd5, 7'd9, 64'hF0E1_D2C3_B4A5_9687 + s, 0, 0, 0, 0);
    // R4 positive and negative immediate with prefetch (R9)
    send(3, 0, 1, 2'd1, 9'd100, 7'd3, 7'd4, 64'h1000, 0, 0, 0, 0);
    send(2, 0, 1, 2'd3, 9'h1F8, 7'd3, 7'd4, 64'h2000, 0, 0, 0, 0);
    // R4 index form
    send(1, 1, 2, 2'd2, 0, 7'd10, 7'd11, 64'h3000_0000, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 0);
    // R6 index poison: tag propagates, no fault, prefetch suppressed
    send(0, 0, 2, 2'd1, 0, 7'd12, 7'd13, 64'h4444, 64'h10, 0, 0, 1);
    // R3 fill with selected spill bit set and clear
    send(0, 2, 0, 0, 0, 7'd20, 7'd21, 64'h0000_0000_0000_01A8, 0, 64'h0020_0000_0000_0000, 0, 0);
    send(1, 2, 1, 0, 9'd8, 7'd20, 7'd21, 64'h0000_0000_0000_01A8, 0, 64'hFFDF_FFFF_FFFF_FFFF, 0, 0);
    // R7 non-speculative poison
    send(3, 0, 0, 0, 0, 7'd1, 7'd2, 64'h5000, 0, 0, 1, 0);
    send(3, 2, 1, 0, 9'd4, 7'd1, 7'd2, 64'h5000, 0, 0, 1, 0);
    // R8 speculative deferral with base update
    send(3, 1, 1, 2'd2, 9'd16, 7'd6, 7'd7, 64'h6000, 0, 0, 1, 0);
    send(2, 1, 0, 0, 0, 7'd6, 7'd7, 64'h6000, 0, 0, 1, 0);
    // R10 illegal, and priority over poison
    send(3, 0, 1, 0, 9'd8, 7'd9, 7'd9, 64'h7000, 0, 0, 0, 0);
    send(3, 0, 2, 0, 0, 7'd9, 7'd9, 64'h7000, 0, 0, 1, 0);
    // no-update form with equal numbers is legal
    send(3, 0, 0, 0, 0, 7'd9, 7'd9, 64'h7008, 0, 0, 0, 0);
    // mixed patterns
    for (int i = 0; i < 80; i++) begin
      logic [1:0] k, f;
      k = 2'($urandom % 3); f = 2'($urandom % 3);
      send(2'($urandom), k, f, 2'($urandom), 9'($urandom),
           7'($urandom % 4), 7'($urandom % 4), {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && dones == sent, "R11 one done per load", dones, sent);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule